// File: doc/BRIEF.md
# Reset-Time Boot Remap Controller

This block chooses the address of the first instruction the CPU fetches after a reset. It holds a small remap register of two fields: a 2-bit select code and a 4-bit upper-address nibble. A 16-bit option word from nonvolatile storage arrives on an input port. A global remap enable, taken from another option word, arrives on a separate input. On a full system reset the register is seeded from the option word, or cleared when the word's mode bit is set. On a CPU-only reset the register keeps whatever software last wrote to it.

When a reset is released, the controller latches a start address, the select code and a remap-active flag. It then raises a done flag, and these outputs stay frozen until the next reset. Software can rewrite the remap register while the CPU runs, but the new value is seen only at the next reset.

The sequencer has three states. `ST_SYS_HOLD` is entered on any cycle with `sys_rst` high. `ST_CPU_HOLD` is entered on any cycle with `cpu_rst` high and `sys_rst` low. From either hold state, the first cycle with both resets low moves to `ST_RUN` and latches the outputs. This is the release transition. `ST_RUN` stays in `ST_RUN` until a reset arrives.

Top module: `boot_remap_ctrl`

## Requirements
- R1: On every clock with `sys_rst` high, the remap register is reloaded from `opt_word`. If bit 15 is 0, the select code takes bits 13:12 and the upper nibble takes bits 11:8. If bit 15 is 1, both fields become zero.
- R2: Option bits 14 and 7:0 have no effect on any output.
- R3: With `remap_en` low at release, the outputs after any reset are `start_addr` = 0x0000, `start_sel` = 0 and `remap_active` = 0.
- R4: With `remap_en` high after a system reset, `remap_active` = 1. `start_addr` carries the upper nibble in bits 15:12 and zeros below it. `start_sel` carries the select code.
- R5: A CPU-only reset does not reload the register from `opt_word`. With `remap_en` high, the start address after such a reset comes from the value software last wrote.
- R6: A write with `wr_en` high in `ST_RUN` updates the register. `wr_data[5:4]` is the select code and `wr_data[3:0]` is the upper nibble. The write leaves `start_addr` and `start_sel` unchanged until the next reset.
- R7: Writes are ignored while either reset is high, and also on the release cycle.
- R8: When `sys_rst` and `cpu_rst` are high together, the system reset wins and the register is reloaded from `opt_word`.
- R9: `boot_done` is low while any reset is high. It goes high at the first clock edge with both resets low, and the latched outputs then hold until the next reset.
- R10: A blank option word (0xFFFF) with `remap_en` high gives `start_addr` = 0x0000 and `remap_active` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Full system reset, synchronous, active high |
| cpu_rst | input | 1 | CPU-only reset, synchronous, active high |
| opt_word | input | 16 | Option word from nonvolatile storage |
| remap_en | input | 1 | Global remap enable from the other option word |
| wr_en | input | 1 | Software write strobe for the remap register |
| wr_data | input | 6 | Write value: [5:4] select code, [3:0] upper nibble |
| start_addr | output | 16 | Latched first-fetch address |
| start_sel | output | 2 | Latched select code |
| remap_active | output | 1 | Remap was applied at the last release |
| boot_done | output | 1 | Start outputs are valid |

## Verification
The hardest case to reach is proving that a CPU-only reset restores a software value rather than the option word. This takes a system reset, a write in `ST_RUN`, and then a CPU-only reset while `opt_word` holds a different, conflicting value. The stimulus covers the writes that must be dropped with three separate cases: a write during each hold state, and a write on the exact release cycle. A following CPU-only reset then brings the register out. Simultaneous resets are driven with a software value that differs from the option word, so that the priority shows at the ports.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
    typedef enum logic [1:0] {
        ST_SYS_HOLD = 2'd0,
        ST_CPU_HOLD = 2'd1,
        ST_RUN      = 2'd2
    } boot_state_e;
endpackage

// File: rtl/boot_remap_reg.sv
module boot_remap_reg #(
    parameter int OPT_W     = 16,
    parameter int SEL_W     = 2,
    parameter int UPPER_W   = 4,
    parameter int MODE_BIT  = 15,
    parameter int SEL_LSB   = 12,
    parameter int UPPER_LSB = 8,
    localparam int REG_W    = SEL_W + UPPER_W
) (
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             cpu_rst,
    input  logic             wr_ok,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [OPT_W-1:0] opt_word,
    output logic [REG_W-1:0] remap_q
);
    logic [REG_W-1:0] seed;
    logic             unused_opt;

    // Reserved option bits reach this module but feed nothing.
    assign unused_opt = ^opt_word;

    always_comb begin
        if (opt_word[MODE_BIT])
            seed = '0;
        else
            seed = {opt_word[SEL_LSB +: SEL_W], opt_word[UPPER_LSB +: UPPER_W]};
    end

    always_ff @(posedge clk) begin
        if (sys_rst)
            remap_q <= seed;
        else if (!cpu_rst && wr_ok && wr_en)
            remap_q <= wr_data;
    end

    // R1: the value after a system reset ends follows the option word.
    a_r1_seed_load: assert property (@(posedge clk) disable iff (sys_rst)
        $fell(sys_rst) |-> remap_q == ($past(opt_word[MODE_BIT]) ? '0 :
            {$past(opt_word[SEL_LSB +: SEL_W]), $past(opt_word[UPPER_LSB +: UPPER_W])}));

    // R5: a CPU-only reset does not touch the register.
    a_r5_cpu_keeps: assert property (@(posedge clk) disable iff (sys_rst)
        cpu_rst |=> $stable(remap_q));

    // R7: no write is taken outside the run state.
    a_r7_no_write_outside_run: assert property (@(posedge clk) disable iff (sys_rst)
        !wr_ok |=> $stable(remap_q));
endmodule

// File: rtl/boot_addr_fmt.sv
module boot_addr_fmt #(
    parameter int ADDR_W  = 16,
    parameter int SEL_W   = 2,
    parameter int UPPER_W = 4,
    localparam int REG_W  = SEL_W + UPPER_W,
    localparam int LOW_W  = ADDR_W - UPPER_W
) (
    input  logic              remap_en,
    input  logic [REG_W-1:0]  remap_q,
    output logic [ADDR_W-1:0] addr_nxt,
    output logic [SEL_W-1:0]  sel_nxt,
    output logic              act_nxt
);
    logic [ADDR_W-1:0] placed;

    generate
        if (LOW_W > 0) begin : g_pad
            assign placed = {remap_q[UPPER_W-1:0], {LOW_W{1'b0}}};
        end else begin : g_flat
            assign placed = remap_q[UPPER_W-1:0];
        end
    endgenerate

    always_comb begin
        if (remap_en) begin
            addr_nxt = placed;
            sel_nxt  = remap_q[REG_W-1 -: SEL_W];
            act_nxt  = 1'b1;
        end else begin
            addr_nxt = '0;
            sel_nxt  = '0;
            act_nxt  = 1'b0;
        end
    end
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
    import boot_remap_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              cpu_rst,
    input  logic [ADDR_W-1:0] addr_nxt,
    input  logic [SEL_W-1:0]  sel_nxt,
    input  logic              act_nxt,
    output logic              run_o,
    output logic              boot_done,
    output logic [ADDR_W-1:0] start_addr,
    output logic [SEL_W-1:0]  start_sel,
    output logic              remap_active
);
    boot_state_e state_q, state_d;
    logic        release_cyc;

    always_comb begin
        state_d = state_q;
        if (sys_rst) begin
            state_d = ST_SYS_HOLD;
        end else if (cpu_rst) begin
            state_d = ST_CPU_HOLD;
        end else begin
            unique case (state_q)
                ST_SYS_HOLD, ST_CPU_HOLD: state_d = ST_RUN;
                ST_RUN:                   state_d = ST_RUN;
                default:                  state_d = ST_SYS_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign run_o       = (state_q == ST_RUN);
    assign release_cyc = !sys_rst && !cpu_rst && (state_q != ST_RUN);

    always_ff @(posedge clk) begin
        if (sys_rst || cpu_rst) begin
            boot_done    <= 1'b0;
            start_addr   <= '0;
            start_sel    <= '0;
            remap_active <= 1'b0;
        end else if (release_cyc) begin
            boot_done    <= 1'b1;
            start_addr   <= addr_nxt;
            start_sel    <= sel_nxt;
            remap_active <= act_nxt;
        end
    end

    // R9: done drops during a CPU-only reset.
    a_r9_done_low_in_reset: assert property (@(posedge clk) disable iff (sys_rst)
        cpu_rst |=> !boot_done);

    // R9: done rises one edge after both resets are low.
    a_r9_done_after_release: assert property (@(posedge clk) disable iff (sys_rst)
        ($past(sys_rst) || $past(cpu_rst)) && !cpu_rst |=> boot_done);

    // R6: outputs hold while running.
    a_r6_hold_in_run: assert property (@(posedge clk) disable iff (sys_rst)
        boot_done && !cpu_rst && !sys_rst |=>
            boot_done && $stable(start_addr) && $stable(start_sel) && $stable(remap_active));
endmodule

// File: rtl/boot_remap_ctrl.sv
module boot_remap_ctrl #(
    parameter int OPT_W     = 16,
    parameter int ADDR_W    = 16,
    parameter int SEL_W     = 2,
    parameter int UPPER_W   = 4,
    parameter int MODE_BIT  = 15,
    parameter int SEL_LSB   = 12,
    parameter int UPPER_LSB = 8,
    localparam int REG_W    = SEL_W + UPPER_W
) (
    input  logic              clk,
    input  logic              sys_rst,
    input  logic              cpu_rst,
    input  logic [OPT_W-1:0]  opt_word,
    input  logic              remap_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [ADDR_W-1:0] start_addr,
    output logic [SEL_W-1:0]  start_sel,
    output logic              remap_active,
    output logic              boot_done
);
    logic [REG_W-1:0]  remap_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [SEL_W-1:0]  sel_nxt;
    logic              act_nxt;
    logic              run_q;

    boot_remap_reg #(
        .OPT_W(OPT_W), .SEL_W(SEL_W), .UPPER_W(UPPER_W),
        .MODE_BIT(MODE_BIT), .SEL_LSB(SEL_LSB), .UPPER_LSB(UPPER_LSB)
    ) u_reg (
        .clk(clk), .sys_rst(sys_rst), .cpu_rst(cpu_rst), .wr_ok(run_q),
        .wr_en(wr_en), .wr_data(wr_data), .opt_word(opt_word), .remap_q(remap_q)
    );

    boot_addr_fmt #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .UPPER_W(UPPER_W)) u_fmt (
        .remap_en(remap_en), .remap_q(remap_q),
        .addr_nxt(addr_nxt), .sel_nxt(sel_nxt), .act_nxt(act_nxt)
    );

    boot_seq_fsm #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_fsm (
        .clk(clk), .sys_rst(sys_rst), .cpu_rst(cpu_rst),
        .addr_nxt(addr_nxt), .sel_nxt(sel_nxt), .act_nxt(act_nxt),
        .run_o(run_q), .boot_done(boot_done), .start_addr(start_addr),
        .start_sel(start_sel), .remap_active(remap_active)
    );

    // R3: remap disabled at release yields address zero and inactive flag.
    a_r3_disabled_zero: assert property (@(posedge clk) disable iff (sys_rst)
        !run_q && !cpu_rst && !remap_en |=> start_addr == '0 && !remap_active);
endmodule

// File: tb/sim_boot_remap_ctrl.sv
module sim_boot_remap_ctrl;
    logic        clk = 1'b0;
    logic        sys_rst = 1'b0;
    logic        cpu_rst = 1'b0;
    logic [15:0] opt_word = 16'hFFFF;
    logic        remap_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_data = '0;
    logic [15:0] start_addr;
    logic [1:0]  start_sel;
    logic        remap_active;
    logic        boot_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    boot_remap_ctrl u0 (
        .clk(clk), .sys_rst(sys_rst), .cpu_rst(cpu_rst), .opt_word(opt_word),
        .remap_en(remap_en), .wr_en(wr_en), .wr_data(wr_data),
        .start_addr(start_addr), .start_sel(start_sel),
        .remap_active(remap_active), .boot_done(boot_done)
    );

    // {opt_word, remap_en, exp_addr, exp_sel, exp_active}
    localparam logic [35:0] VEC [8] = '{
        {16'h0A00, 1'b1, 16'hA000, 2'd0, 1'b1},   // R4
        {16'h3500, 1'b1, 16'h5000, 2'd3, 1'b1},   // R4
        {16'h1700, 1'b1, 16'h7000, 2'd1, 1'b1},   // R4
        {16'h8A00, 1'b1, 16'h0000, 2'd0, 1'b1},   // R1 mode bit set
        {16'hFFFF, 1'b1, 16'h0000, 2'd0, 1'b1},   // R10 blank word
        {16'h0A00, 1'b0, 16'h0000, 2'd0, 1'b0},   // R3
        {16'h2C00, 1'b1, 16'hC000, 2'd2, 1'b1},   // R2 reference
        {16'h6CFF, 1'b1, 16'hC000, 2'd2, 1'b1}    // R2 reserved bits set
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [15:0] a, input logic [1:0] s,
                           input logic act);
        chk({tag, " addr"}, {16'h0, start_addr}, {16'h0, a});
        chk({tag, " sel"}, {30'h0, start_sel}, {30'h0, s});
        chk({tag, " active"}, {31'h0, remap_active}, {31'h0, act});
        chk({tag, " done"}, {31'h0, boot_done}, 32'h1);
    endtask

    task automatic sys_reset(input logic [15:0] opt, input logic en);
        @(negedge clk);
        sys_rst = 1'b1; opt_word = opt; remap_en = en;
        @(negedge clk);
        @(negedge clk);
        sys_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_reset(input logic en);
        @(negedge clk);
        cpu_rst = 1'b1; remap_en = en;
        @(negedge clk);
        @(negedge clk);
        cpu_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_write(input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state, R9
        @(negedge clk);
        sys_rst = 1'b1; opt_word = 16'h0A00; remap_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 done low in system reset", {31'h0, boot_done}, 32'h0);
        chk("R9 addr zero in reset", {16'h0, start_addr}, 32'h0);
        sys_rst = 1'b0;
        @(negedge clk);
        chk_out("R9 release", 16'hA000, 2'd0, 1'b1);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            sys_reset(VEC[i][35:20], VEC[i][19]);
            chk_out($sformatf("R1/R4 vector %0d", i), VEC[i][18:3], VEC[i][2:1], VEC[i][0]);
        end

        // R6: write in run does not move outputs, R5: CPU reset uses it
        sys_reset(16'h0A00, 1'b1);
        sw_write(6'h37);
        @(negedge clk);
        chk_out("R6 outputs held after write", 16'hA000, 2'd0, 1'b1);
        @(negedge clk);
        cpu_rst = 1'b1; opt_word = 16'h0200; remap_en = 1'b1;
        @(negedge clk);
        chk("R9 done low in cpu reset", {31'h0, boot_done}, 32'h0);
        @(negedge clk);
        cpu_rst = 1'b0;
        @(negedge clk);
        chk_out("R5 cpu reset uses software value", 16'h7000, 2'd3, 1'b1);

        // R3 on CPU-only reset
        cpu_reset(1'b0);
        chk_out("R3 cpu reset remap disabled", 16'h0000, 2'd0, 1'b0);

        // R7: write during system reset hold is dropped
        @(negedge clk);
        sys_rst = 1'b1; opt_word = 16'h0100; remap_en = 1'b1;
        wr_en = 1'b1; wr_data = 6'h2F;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0; sys_rst = 1'b0;
        @(negedge clk);
        chk_out("R7 write in system hold", 16'h1000, 2'd0, 1'b1);

        // R7: write during CPU hold and on the release cycle are dropped
        @(negedge clk);
        cpu_rst = 1'b1; wr_en = 1'b1; wr_data = 6'h2F;
        @(negedge clk);
        @(negedge clk);
        cpu_rst = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        chk_out("R7 write in cpu hold and release", 16'h1000, 2'd0, 1'b1);
        cpu_reset(1'b1);
        chk_out("R7 register kept after dropped writes", 16'h1000, 2'd0, 1'b1);

        // R8: simultaneous resets favour the option word
        sw_write(6'h15);
        @(negedge clk);
        sys_rst = 1'b1; cpu_rst = 1'b1; opt_word = 16'h0900; remap_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 done low in both resets", {31'h0, boot_done}, 32'h0);
        sys_rst = 1'b0; cpu_rst = 1'b0;
        @(negedge clk);
        chk_out("R8 system reset priority", 16'h9000, 2'd0, 1'b1);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule